// File: doc/BRIEF.md
# Prescaled Center-Aligned PWM Timer

This block produces one PWM output per channel from a time base that can count up only or up and then back down. A shared global divider slows the system clock. Each channel then divides that rate again with its own divider, which gives the channel's count enable. In up-down mode a programmed tick count P makes a period of 2·P count steps. The output is active around the counter minimum, so each pulse is symmetric about the turning point at zero. In up-only mode the period is P+1 count steps and the output is edge-aligned.

Each channel gives a one-clock trigger at the start of every period, for example to start an ADC conversion. Software writes the dividers, period, duty and mode through a simple write port. Period, duty and mode go to shadow registers. They reach the active registers only when the counter returns to zero, so a period is never cut short or distorted. In up-down mode the duty is scaled against twice the period. A duty of 0 means always inactive. A duty of 2·P−2 or more means always active.

Top module: `pwm_center_timer`

## Requirements
- R1: After reset every output and every trigger is low, and a channel stays idle until a non-zero period has been loaded.
- R2: A channel's counter advances once every (G+1)·(C+1) clocks, where G is the global divider (address group 0, field 0) and C is the channel divider (field 0 of the channel group).
- R3: In up-down mode (mode field bit 0 = 1) the counter runs 0,1,…,P,P−1,…,1, so one period lasts 2·P count steps, that is 2·P·(G+1)·(C+1) clocks.
- R4: In up-only mode (mode field bit 0 = 0) the counter runs 0…P, so one period lasts (P+1)·(G+1)·(C+1) clocks.
- R5: In up-down mode with 0 < D < 2·P−2, the output is active in each count step where 2·count < D. That gives 2·⌈D/2⌉−1 active steps per period, centred on count 0 and active during the trigger cycle. D = P gives about half the period.
- R6: A duty of 0 keeps the output inactive for the whole period in either mode.
- R7: In up-down mode any duty D ≥ 2·P−2 (with D ≠ 0) keeps the output active for the whole period. Larger values saturate and do not wrap.
- R8: In up-only mode the output is active while count < D, so D ≥ P+1 means fully active.
- R9: A period, duty or mode write takes effect only at the next return of the counter to zero. The period in progress keeps its old length.
- R10: The trigger is high for exactly one clock: the first clock in which a new period's count of 0 is present.
- R11: Writes use wr_addr = {group, field}. Group 0 is global, and group c+1 selects channel c. Field 0 is the divider, 1 the period, 2 the duty and 3 the mode. A write to one channel does not change another channel.
- R12: An active period of 0 makes the channel idle: no trigger and an inactive output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | {group, field} write address |
| wr_data | input | CNT_W | Write data |
| pwm_o | output | NUM_CH | PWM outputs, one per channel |
| trig_o | output | NUM_CH | Start-of-period pulses, one per channel |

## Verification
A register write takes one clock. Its effect on the waveform is due only from the trigger that follows the next wrap, so after every reconfiguration the bench drops one whole period and measures the next one, from trigger to trigger. The trigger rises one clock after the enable that wraps the counter. Each count value then holds for exactly (G+1)·(C+1) clocks, so period and active lengths come out as whole multiples of that product, and the bench compares them with closed-form functions. For the shadow check, the bench times the gap between two triggers that span a mid-period write. That gap must equal the old period.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

   localparam int FLD_W = 2;

   localparam logic [FLD_W-1:0] FLD_DIV    = 2'd0;
   localparam logic [FLD_W-1:0] FLD_PERIOD = 2'd1;
   localparam logic [FLD_W-1:0] FLD_DUTY   = 2'd2;
   localparam logic [FLD_W-1:0] FLD_MODE   = 2'd3;

   typedef enum logic {
      CNT_UP     = 1'b0,
      CNT_UPDOWN = 1'b1
   } cnt_mode_e;

endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_tick,
   input  logic [W-1:0] div,
   output logic         tick_o
);
   logic [W-1:0] cnt_q;
   logic         at_top;

   // >= lets a lowered divisor take effect without a long wrap-around
   assign at_top = (cnt_q >= div);
   assign tick_o = in_tick && at_top;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (in_tick) cnt_q <= at_top ? '0 : cnt_q + W'(1);
   end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cnt_en,
   input  logic [W-1:0] period,
   input  logic         updown,
   output logic [W-1:0] cnt_o,
   output logic         wrap_o
);
   logic dir_up_q;
   logic idle;
   logic last_step;

   assign idle = (period == '0);

   always_comb begin
      if (updown) last_step = !dir_up_q && (cnt_o <= W'(1));
      else        last_step = (cnt_o >= period);
   end

   assign wrap_o = cnt_en && (idle || last_step);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_o    <= '0;
         dir_up_q <= 1'b1;
      end else if (wrap_o) begin
         cnt_o    <= '0;
         dir_up_q <= 1'b1;
      end else if (cnt_en) begin
         if (updown && !dir_up_q) begin
            cnt_o <= cnt_o - W'(1);
         end else begin
            cnt_o <= cnt_o + W'(1);
            if (updown && (cnt_o >= period - W'(1))) dir_up_q <= 1'b0;
         end
      end
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      !idle |-> (cnt_o <= period)); // R3
   AST_DOWN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (updown && !dir_up_q) |-> (cnt_o != '0)); // R3
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
   import pwm_pkg::*;
#(
   parameter int W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             base_tick,
   input  logic             wr_en,
   input  logic [FLD_W-1:0] wr_fld,
   input  logic [W-1:0]     wr_data,
   output logic             pwm_o,
   output logic             trig_o
);
   logic [W-1:0] div_q;
   logic [W-1:0] sh_period, sh_duty;
   logic [W-1:0] act_period, act_duty;
   cnt_mode_e    sh_mode, act_mode;
   logic         cnt_en, wrap, trig_q, updown;
   logic [W-1:0] cnt;
   logic [W:0]   full_code, cnt_x2, duty_x;

   // divider applies at once; period/duty/mode wait in shadows
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q     <= '0;
         sh_period <= '0;
         sh_duty   <= '0;
         sh_mode   <= CNT_UPDOWN;
      end else if (wr_en) begin
         case (wr_fld)
            FLD_DIV:    div_q     <= wr_data;
            FLD_PERIOD: sh_period <= wr_data;
            FLD_DUTY:   sh_duty   <= wr_data;
            default:    sh_mode   <= cnt_mode_e'(wr_data[0]);
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_period <= '0;
         act_duty   <= '0;
         act_mode   <= CNT_UPDOWN;
         trig_q     <= 1'b0;
      end else if (wrap) begin
         act_period <= sh_period;
         act_duty   <= sh_duty;
         act_mode   <= sh_mode;
         trig_q     <= (sh_period != '0);
      end else begin
         trig_q     <= 1'b0;
      end
   end

   assign updown = (act_mode == CNT_UPDOWN);
   assign trig_o = trig_q;

   pwm_prescale #(.W(W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_tick (base_tick),
      .div     (div_q),
      .tick_o  (cnt_en)
   );

   pwm_timebase #(.W(W)) u_tb (
      .clk     (clk),
      .rst_n   (rst_n),
      .cnt_en  (cnt_en),
      .period  (act_period),
      .updown  (updown),
      .cnt_o   (cnt),
      .wrap_o  (wrap)
   );

   // duty is measured against 2*period in up-down mode
   assign full_code = {act_period, 1'b0} - (W+1)'(2);
   assign cnt_x2    = {cnt, 1'b0};
   assign duty_x    = {1'b0, act_duty};

   always_comb begin
      if (act_period == '0 || act_duty == '0) pwm_o = 1'b0;
      else if (updown) pwm_o = (duty_x >= full_code) || (cnt_x2 < duty_x);
      else             pwm_o = (cnt < act_duty);
   end

   AST_TRIG_AT_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      trig_o |-> (cnt == '0)); // R10
   AST_TRIG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      trig_o |=> !trig_o); // R10
   AST_START_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_o && act_duty != '0) |-> pwm_o); // R5
   AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap |=> ($stable(act_period) && $stable(act_duty) && $stable(act_mode))); // R9
   AST_IDLE_NO_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
      (act_period == '0) |-> !trig_o); // R12
endmodule

// File: rtl/pwm_center_timer.sv
module pwm_center_timer
   import pwm_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int NUM_CH = 2,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   output logic [NUM_CH-1:0] pwm_o,
   output logic [NUM_CH-1:0] trig_o
);
   localparam int GRP_W = ADDR_W - FLD_W;

   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
      $error("CNT_W must lie in 2..32");
   end
   if (NUM_CH < 1) begin : g_bad_count
      $error("NUM_CH must be at least 1");
   end
   if (GRP_W < 1 || (1 << GRP_W) < NUM_CH + 1) begin : g_bad_addr
      $error("ADDR_W too narrow for NUM_CH channel groups");
   end

   logic [GRP_W-1:0] wr_grp;
   logic [FLD_W-1:0] wr_fld;
   logic [CNT_W-1:0] gdiv_q;
   logic             gtick;

   assign wr_grp = wr_addr[ADDR_W-1:FLD_W];
   assign wr_fld = wr_addr[FLD_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gdiv_q <= '0;
      else if (wr_en && wr_grp == '0 && wr_fld == FLD_DIV) gdiv_q <= wr_data;
   end

   pwm_prescale #(.W(CNT_W)) u_gdiv (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_tick (1'b1),
      .div     (gdiv_q),
      .tick_o  (gtick)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic ch_wr;
      assign ch_wr = wr_en && (wr_grp == GRP_W'(c + 1));

      pwm_channel #(.W(CNT_W)) u_ch (
         .clk       (clk),
         .rst_n     (rst_n),
         .base_tick (gtick),
         .wr_en     (ch_wr),
         .wr_fld    (wr_fld),
         .wr_data   (wr_data),
         .pwm_o     (pwm_o[c]),
         .trig_o    (trig_o[c])
      );

      AST_TRIG_AFTER_BASE: assert property (@(posedge clk) disable iff (!rst_n)
         trig_o[c] |-> $past(gtick)); // R2
   end
endmodule

// File: tb/sim_pwm_center_timer.sv
module sim_pwm_center_timer;
   localparam int NCH = 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            wr_en = 1'b0;
   logic [3:0]      wr_addr = '0;
   logic [15:0]     wr_data = '0;
   logic [NCH-1:0]  pwm_o;
   logic [NCH-1:0]  trig_o;

   int checks = 0;
   int fails = 0;
   int cyc = 0;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   pwm_center_timer u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .pwm_o(pwm_o), .trig_o(trig_o)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // R11: address = {group, field}
   task automatic wr(input int grp, input int fld, input int val);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_addr = 4'((grp << 2) | fld);
      wr_data = 16'(val);
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   // period written last so an idle channel starts on a full setup
   task automatic cfg(input int ch, input int p, input int d, input int ud, input int cdiv);
      wr(ch + 1, 0, cdiv);
      wr(ch + 1, 2, d);
      wr(ch + 1, 3, ud);
      wr(ch + 1, 1, p);
   endtask

   task automatic wait_trig(input int ch, output bit ok, output int t);
      ok = 1'b0;
      t  = 0;
      for (int i = 0; i < 40000; i++) begin
         @(negedge clk);
         if (trig_o[ch]) begin ok = 1'b1; t = cyc; return; end
      end
   endtask

   task automatic measure(input int ch, output int per, output int hi,
                          output bit first_hi, output bit ok);
      int t;
      per = 0; hi = 0; first_hi = 1'b0;
      wait_trig(ch, ok, t);
      if (!ok) return;
      per = 1;
      hi = int'(pwm_o[ch]);
      first_hi = pwm_o[ch];
      for (int i = 0; i < 40000; i++) begin
         @(negedge clk);
         if (trig_o[ch]) return;
         per++;
         hi += int'(pwm_o[ch]);
      end
      ok = 1'b0;
   endtask

   function automatic int exp_steps(input int p, input int ud);
      return (ud != 0) ? 2 * p : p + 1;
   endfunction

   function automatic int exp_active(input int p, input int d, input int ud);
      if (d == 0) return 0;
      if (ud != 0) begin
         if (d >= 2 * p - 2) return 2 * p;
         return 2 * ((d + 1) / 2) - 1;
      end
      return (d < p + 1) ? d : p + 1;
   endfunction

   task automatic run_case(input int ch, input int p, input int d, input int ud,
                           input int g, input int cdiv, input string tag);
      int per, hi, t, n;
      bit fh, ok;
      n = (g + 1) * (cdiv + 1);
      cfg(ch, p, d, ud, cdiv);
      wait_trig(ch, ok, t);
      measure(ch, per, hi, fh, ok);
      chk(ok, {tag, " trigger seen"}, int'(ok), 1);
      chk(per == exp_steps(p, ud) * n, {tag, " period clocks"}, per, exp_steps(p, ud) * n);
      chk(hi == exp_active(p, d, ud) * n, {tag, " active clocks"}, hi, exp_active(p, d, ud) * n);
      chk(fh == (d != 0), {tag, " active at trigger"}, int'(fh), int'(d != 0));
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 200000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : main
      int per, hi, t0, t1, trig_seen, pwm_seen;
      bit fh, ok;
      void'($urandom(32'd20240611));

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: quiet after reset
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         chk(pwm_o == '0, "R1 pwm low after reset", int'(pwm_o), 0);
         chk(trig_o == '0, "R1 trigger low after reset", int'(trig_o), 0);
      end

      // R3 R5: large period, D = P gives close to half
      run_case(0, 8000, 8000, 1, 0, 0, "R3 R5 p8000 d8000");
      // R7: exact full code and saturation
      run_case(0, 100, 198, 1, 0, 0, "R7 full code");
      run_case(0, 100, 60000, 1, 0, 0, "R7 saturate");
      // R6: zero duty in both modes
      run_case(0, 10, 0, 1, 0, 0, "R6 zero duty up-down");
      run_case(0, 10, 0, 0, 0, 0, "R6 zero duty up-only");
      // R4 R8: up-only
      run_case(0, 5, 3, 0, 0, 0, "R4 R8 up-only d3");
      run_case(0, 5, 10, 0, 0, 0, "R8 up-only full");
      // R2: both dividers
      wr(0, 0, 2);
      run_case(1, 6, 5, 1, 2, 1, "R2 divided");
      wr(0, 0, 0);
      // R5: smallest period
      run_case(1, 1, 1, 1, 0, 0, "R5 R7 period one");

      // R10: pulse width one clock with undivided enable
      wait_trig(1, ok, t0);
      @(negedge clk);
      chk(trig_o[1] == 1'b0, "R10 trigger one clock", int'(trig_o[1]), 0);

      // R9: mid-period write does not alter running period
      run_case(0, 20, 10, 1, 0, 0, "R9 base");
      wait_trig(0, ok, t0);
      repeat (3) @(negedge clk);
      wr(1, 1, 10);
      wr(1, 2, 4);
      wait_trig(0, ok, t1);
      chk(t1 - t0 == 40, "R9 old period kept", t1 - t0, 40);
      measure(0, per, hi, fh, ok);
      chk(per == 20, "R9 new period applied", per, 20);
      chk(hi == 3, "R9 new duty applied", hi, 3);

      // R11: write to channel 1 leaves channel 0 alone
      cfg(1, 3, 2, 0, 0);
      measure(0, per, hi, fh, ok);
      chk(per == 20, "R11 channel isolation period", per, 20);
      chk(hi == 3, "R11 channel isolation duty", hi, 3);

      // random mix, R5 R8 R2
      for (int k = 0; k < 12; k++) begin
         int ch, p, d, ud, g, cd;
         ch = int'($urandom_range(0, NCH - 1));
         p  = int'($urandom_range(1, 12));
         d  = int'($urandom_range(0, 2 * p + 2));
         ud = int'($urandom_range(0, 1));
         g  = int'($urandom_range(0, 2));
         cd = int'($urandom_range(0, 2));
         wr(0, 0, g);
         run_case(ch, p, d, ud, g, cd, "R5 R8 random");
      end
      wr(0, 0, 0);

      // R12: period 0 idles the channel
      cfg(1, 4, 3, 1, 0);
      wait_trig(1, ok, t0);
      wr(2, 1, 0);
      repeat (20) @(negedge clk);
      trig_seen = 0;
      pwm_seen  = 0;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         trig_seen += int'(trig_o[1]);
         pwm_seen  += int'(pwm_o[1]);
      end
      chk(trig_seen == 0, "R12 idle no trigger", trig_seen, 0);
      chk(pwm_seen == 0, "R12 idle output low", pwm_seen, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule